// File: doc/BRIEF.md
# Probed Serial Trace-Code Reporter

This block sends 32-bit progress codes to an optional debug device on a chip-select serial link. A debug device may or may not be fitted. One probe, started after reset, finds out which case applies: the block clocks out two zero command bytes, clocks in a four-byte identifier, deselects the device and holds the result in `probe_ok`. The identifier must equal 0x04120000.

The surrounding logic then raises `req_valid` with a code for each milestone. If the probe matched, the request becomes one framed write: select, a 0xA0 command byte, the four code bytes, then deselect. If the probe did not match, the request is dropped and the link stays quiet. Every transfer step waits for the byte shifter to finish. After each deselect the block spends two settle cycles, which stand for the two control read-backs, before it returns to idle. The link clock is the system clock divided by a parameter, set by default to four, so a 32 MHz fast clock gives an 8 MHz link.

Top module: `tr_trace_reporter`

## Requirements
- R1: While reset is held and just after it, `busy`=0, `done`=0, `probe_ok`=0, `link_cs_n`=1 and `link_sck`=0.
- R2: A probe frame is one select window carrying exactly 48 link clocks, all with `link_mosi`=0: two command bytes, then four identifier bytes read from `link_miso`.
- R3: At the end of a probe, `probe_ok` becomes 1 exactly when the identifier, assembled most significant bit first, equals 0x04120000. It changes at no other time.
- R4: An accepted write is one select window of exactly 40 link clocks. The bits are 0xA0 followed by the code, most significant byte first and most significant bit first.
- R5: A request made while `probe_ok`=0 produces no select activity. `done` pulses in the next cycle and `busy` stays 0.
- R6: `busy` rises in the cycle after a probe or request is accepted. It stays high for N*(8*DIV+2)+3 cycles, where N is 6 for a probe and 5 for a write.
- R7: `done` is high for one cycle, in the first idle cycle after a write. It never pulses after a probe.
- R8: `probe_start` and `req_valid` are ignored while `busy`=1. A write with such pulses produces exactly one frame.
- R9: `link_sck` is low whenever `link_cs_n`=1. Within a byte, rising edges are DIV cycles apart, and data is sampled on the rising edge.
- R10: If `probe_start` and `req_valid` arrive together while idle, the probe is taken and the request is discarded.
- R11: A later probe that reads an identifier other than 0x04120000 clears `probe_ok`, and after that requests are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_start | input | 1 | Starts the identifier probe when idle |
| req_valid | input | 1 | Trace-code request strobe |
| req_code | input | 32 | Code to publish |
| busy | output | 1 | A probe or write is in progress |
| done | output | 1 | One-cycle pulse when a request ends (written or dropped) |
| probe_ok | output | 1 | Probe matched the expected identifier |
| link_cs_n | output | 1 | Device select, active low |
| link_sck | output | 1 | Link clock, idle low |
| link_mosi | output | 1 | Data to device |
| link_miso | input | 1 | Data from device |

## Verification
The embedded properties assume three things. Inputs change away from the clock edge. `link_miso` is stable at each rising edge of `link_sck`. `rst_n` is asserted at the start. The bench drives every input at the falling clock edge. Its device model moves `link_miso` only on falling `link_sck` edges or when the device is selected. Requests arrive as single-cycle pulses, and some of them deliberately overlap busy periods or coincide with `probe_start`.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DESEL,
    ST_RB1,
    ST_RB2
  } tr_state_e;

  typedef enum logic {
    OP_PROBE,
    OP_WRITE
  } tr_op_e;
endpackage

// File: rtl/tr_byte_shifter.sv
module tr_byte_shifter #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] byte_o
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] PH_RISE = PW'(DIV / 2 - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    tx_q, tx_d, rx_q, rx_d;
  logic          busy_q, busy_d, sck_q, sck_d, done_q, done_d;

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    busy_d  = busy_q;
    sck_d   = sck_q;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        tx_d    = byte_i;
        busy_d  = 1'b1;
        phase_d = '0;
        bit_d   = '0;
        sck_d   = 1'b0;
      end
    end else if (phase_q == PH_RISE) begin
      sck_d   = 1'b1;
      rx_d    = {rx_q[6:0], miso_i};
      phase_d = phase_q + 1'b1;
    end else if (phase_q == PH_LAST) begin
      sck_d   = 1'b0;
      phase_d = '0;
      tx_d    = {tx_q[6:0], 1'b0};
      if (bit_q == 3'd7) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      busy_q  <= busy_d;
      sck_q   <= sck_d;
      done_q  <= done_d;
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign byte_o = rx_q;

  // R6: the sequencer never restarts the shifter in the middle of a byte
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);
endmodule

// File: rtl/tr_sequencer.sv
module tr_sequencer
  import tr_pkg::*;
#(
  parameter int          CODE_W    = 32,
  parameter int          ID_W      = 32,
  parameter int          CMD_BYTES = 2,
  parameter logic [31:0] EXPECT_ID = 32'h0412_0000,
  parameter logic [7:0]  WR_CMD    = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_start_i,
  input  logic              req_valid_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              xfer_done_i,
  input  logic [7:0]        rx_byte_i,
  output logic              start_o,
  output logic [7:0]        tx_byte_o,
  output logic              cs_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              probe_ok_o
);
  localparam int PROBE_LEN = CMD_BYTES + ID_W / 8;
  localparam int WRITE_LEN = 1 + CODE_W / 8;
  localparam int MAX_LEN   = (PROBE_LEN > WRITE_LEN) ? PROBE_LEN : WRITE_LEN;
  localparam int IW        = $clog2(MAX_LEN);
  localparam logic [IW-1:0] PROBE_LAST = IW'(PROBE_LEN - 1);
  localparam logic [IW-1:0] WRITE_LAST = IW'(WRITE_LEN - 1);
  localparam logic [IW-1:0] ID_FIRST   = IW'(CMD_BYTES);

  tr_state_e         state_q, state_d;
  tr_op_e            op_q, op_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic              ok_q, ok_d, done_q, done_d;
  logic [IW-1:0]     last_idx;

  assign last_idx = (op_q == OP_PROBE) ? PROBE_LAST : WRITE_LAST;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    idx_d   = idx_q;
    code_d  = code_q;
    id_d    = id_q;
    ok_d    = ok_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (probe_start_i) begin
          op_d    = OP_PROBE;
          idx_d   = '0;
          id_d    = '0;
          state_d = ST_ISSUE;
        end else if (req_valid_i) begin
          if (ok_q) begin
            op_d    = OP_WRITE;
            idx_d   = '0;
            code_d  = req_code_i;
            state_d = ST_ISSUE;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (xfer_done_i) begin
          if (op_q == OP_PROBE && idx_q >= ID_FIRST)
            id_d = {id_q[ID_W-9:0], rx_byte_i};
          if (op_q == OP_WRITE && idx_q != '0)
            code_d = {code_q[CODE_W-9:0], 8'h00};
          if (idx_q == last_idx) begin
            state_d = ST_DESEL;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_DESEL: state_d = ST_RB1;
      ST_RB1:   state_d = ST_RB2;
      ST_RB2: begin
        state_d = ST_IDLE;
        if (op_q == OP_PROBE) ok_d = (id_q == ID_W'(EXPECT_ID));
        else                  done_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PROBE;
      idx_q   <= '0;
      code_q  <= '0;
      id_q    <= '0;
      ok_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      idx_q   <= idx_d;
      code_q  <= code_d;
      id_q    <= id_d;
      ok_q    <= ok_d;
      done_q  <= done_d;
    end
  end

  assign start_o    = (state_q == ST_ISSUE);
  assign tx_byte_o  = (op_q == OP_PROBE) ? 8'h00 :
                      (idx_q == '0) ? WR_CMD : code_q[CODE_W-1 -: 8];
  assign cs_n_o     = !(state_q == ST_ISSUE || state_q == ST_WAIT);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign probe_ok_o = ok_q;

  // R3: the match flag only moves on the final settle cycle of a probe
  assert_ok_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RB2) |=> $stable(ok_q));
  // R7: completion is reported only from idle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));
  // R5: an unmatched request is answered at once and leaves the link alone
  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && req_valid_i && !probe_start_i && !ok_q)
      |=> (state_q == ST_IDLE && done_q));
endmodule

// File: rtl/tr_trace_reporter.sv
module tr_trace_reporter #(
  parameter int          DIV       = 4,
  parameter logic [31:0] EXPECT_ID = 32'h0412_0000,
  parameter logic [7:0]  WR_CMD    = 8'hA0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        probe_start,
  input  logic        req_valid,
  input  logic [31:0] req_code,
  output logic        busy,
  output logic        done,
  output logic        probe_ok,
  output logic        link_cs_n,
  output logic        link_sck,
  output logic        link_mosi,
  input  logic        link_miso
);
  logic       sh_start, sh_busy, sh_done;
  logic [7:0] sh_tx, sh_rx;

  tr_sequencer #(
    .CODE_W   (32),
    .ID_W     (32),
    .CMD_BYTES(2),
    .EXPECT_ID(EXPECT_ID),
    .WR_CMD   (WR_CMD)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .probe_start_i(probe_start),
    .req_valid_i  (req_valid),
    .req_code_i   (req_code),
    .xfer_done_i  (sh_done),
    .rx_byte_i    (sh_rx),
    .start_o      (sh_start),
    .tx_byte_o    (sh_tx),
    .cs_n_o       (link_cs_n),
    .busy_o       (busy),
    .done_o       (done),
    .probe_ok_o   (probe_ok)
  );

  tr_byte_shifter #(.DIV(DIV)) shift_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(sh_start),
    .byte_i (sh_tx),
    .miso_i (link_miso),
    .sck_o  (link_sck),
    .mosi_o (link_mosi),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .byte_o (sh_rx)
  );

  // R2 / R4: every shifted bit lies inside a select window
  assert_shift_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !link_cs_n);
  // R9: link clock rests low outside a select window
  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_cs_n |-> !link_sck);
  // R7: completion never coincides with activity
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tr_trace_reporter_tb.sv
`timescale 1ns/1ps
module tr_trace_reporter_tb_top;
  localparam int DIV      = 4;
  localparam int BYTE_CYC = 8 * DIV + 2;
  localparam int T_PROBE  = 6 * BYTE_CYC + 3;
  localparam int T_WRITE  = 5 * BYTE_CYC + 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, probe_start, req_valid;
  logic [31:0] req_code;
  logic        busy, done, probe_ok, link_cs_n, link_sck, link_mosi, link_miso;

  tr_trace_reporter #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .probe_start(probe_start), .req_valid(req_valid),
    .req_code(req_code), .busy(busy), .done(done), .probe_ok(probe_ok),
    .link_cs_n(link_cs_n), .link_sck(link_sck), .link_mosi(link_mosi),
    .link_miso(link_miso)
  );

  // ---------------- device model ----------------
  logic [31:0] dev_id;
  logic [47:0] dev_out;
  logic [63:0] cap, last_frame;
  int          cap_bits, last_bits, frames;

  initial begin
    dev_out = '0; cap = '0; last_frame = '0;
    cap_bits = 0; last_bits = 0; frames = 0;
  end
  always @(negedge link_cs_n) begin
    dev_out  = {16'h0000, dev_id};
    cap      = '0;
    cap_bits = 0;
  end
  always @(posedge link_sck) begin
    cap      = {cap[62:0], link_mosi};
    cap_bits = cap_bits + 1;
  end
  always @(negedge link_sck) if (link_cs_n === 1'b0) dev_out = dev_out << 1;
  always @(posedge link_cs_n) begin
    last_frame = cap;
    last_bits  = cap_bits;
    frames     = frames + 1;
  end
  assign link_miso = dev_out[47];

  // ---------------- bookkeeping ----------------
  int nchecks = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int left = 0;
  bit m_probe = 0, exp_done = 0, exp_ok = 0;
  int rise_n = 0, last_rise = 0;
  logic prev_sck = 1'b0;

  task automatic tick(input bit p, input bit r, input logic [31:0] c);
    bit nd;
    @(negedge clk);
    cyc++;
    chk(busy == (left > 0), "R6 busy", 64'(busy), 64'(left > 0));
    chk(done == exp_done, "R7 done", 64'(done), 64'(exp_done));
    chk(probe_ok == exp_ok, "R3 probe_ok", 64'(probe_ok), 64'(exp_ok));
    if (left == 0) chk(link_cs_n == 1'b1, "R5 cs idle", 64'(link_cs_n), 64'd1);
    if (link_cs_n) chk(link_sck == 1'b0, "R9 sck idle", 64'(link_sck), 64'd0);
    if (link_cs_n) rise_n = 0;
    else if (link_sck && !prev_sck) begin
      if (rise_n % 8 != 0)
        chk(cyc - last_rise == DIV, "R9 sck period", 64'(cyc - last_rise), 64'(DIV));
      rise_n++;
      last_rise = cyc;
    end
    prev_sck = link_sck;
    nd = 0;
    if (left > 0) begin
      left--;
      if (left == 0) begin
        if (m_probe) exp_ok = (dev_id == 32'h0412_0000);
        else         nd = 1;
      end
    end else if (p) begin
      left = T_PROBE; m_probe = 1;
    end else if (r) begin
      if (exp_ok) begin left = T_WRITE; m_probe = 0; end
      else nd = 1;
    end
    exp_done    = nd;
    probe_start = p;
    req_valid   = r;
    req_code    = c;
  endtask

  task automatic finish_op();
    while (left > 0) tick(0, 0, 32'h0);
    tick(0, 0, 32'h0);
  endtask

  task automatic do_probe(input string tag);
    int f0;
    f0 = frames;
    tick(1, 0, 32'h0);
    finish_op();
    chk(frames == f0 + 1, {tag, " probe frame count"}, 64'(frames), 64'(f0 + 1));
    chk(last_bits == 48, "R2 probe bits", 64'(last_bits), 64'd48);
    chk(last_frame[47:0] == 48'h0, "R2 probe mosi", last_frame, 64'h0);
  endtask

  task automatic do_write(input logic [31:0] code, input bit disturb);
    int f0;
    f0 = frames;
    tick(0, 1, code);
    if (disturb) begin
      repeat (20) tick(0, 0, 32'h0);
      tick(0, 1, ~code);
      repeat (40) tick(0, 0, 32'h0);
      tick(1, 0, 32'h0);   // R8 probe ignored while busy
    end
    finish_op();
    chk(frames == f0 + 1, "R8 one frame", 64'(frames), 64'(f0 + 1));
    chk(last_bits == 40, "R4 write bits", 64'(last_bits), 64'd40);
    chk(last_frame[39:0] == {8'hA0, code}, "R4 write frame",
        64'(last_frame[39:0]), 64'({8'hA0, code}));
  endtask

  task automatic do_drop(input logic [31:0] code);
    int f0;
    f0 = frames;
    tick(0, 1, code);
    repeat (3) tick(0, 0, 32'h0);
    chk(frames == f0, "R5 dropped no frame", 64'(frames), 64'(f0));
  endtask

  initial begin
    rst_n = 1'b0; probe_start = 1'b0; req_valid = 1'b0; req_code = '0;
    dev_id = 32'h0412_0000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0 && probe_ok == 0, "R1 status", {busy, done, probe_ok}, 0);
    chk(link_cs_n == 1 && link_sck == 0, "R1 link", {link_cs_n, link_sck}, 64'h2);
    rst_n = 1'b1;
    repeat (3) tick(0, 0, 32'h0);
    chk(probe_ok == 0, "R1 after release", 64'(probe_ok), 0);

    do_drop(32'hDEAD_BEEF);           // R5 before probe
    do_probe("R2");                   // R2 R3 matching id
    chk(probe_ok == 1, "R3 matched", 64'(probe_ok), 1);
    do_write(32'h1234_5678, 0);       // R4
    do_write(32'hFFFF_FFFF, 1);       // R4 R8
    do_write(32'h0000_0001, 0);
    do_write(32'hA5C3_0F96, 1);
    repeat (2) tick(0, 0, 32'h0);

    // R10: probe and request together, probe wins
    begin
      int f0;
      f0 = frames;
      tick(1, 1, 32'h5555_AAAA);
      finish_op();
      chk(frames == f0 + 1, "R10 single frame", 64'(frames), 64'(f0 + 1));
      chk(last_bits == 48, "R10 probe taken", 64'(last_bits), 64'd48);
    end

    // R11: mismatching id in the lowest bit clears the flag
    dev_id = 32'h0412_0001;
    do_probe("R11");
    chk(probe_ok == 0, "R11 cleared", 64'(probe_ok), 0);
    do_drop(32'h0BAD_F00D);

    // back to a matching device
    dev_id = 32'h0412_0000;
    do_probe("R3");
    do_write(32'h8000_0000, 0);
    repeat (4) tick(0, 0, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchecks++;
      nfail++;
      $display("FAIL watchdog expired cycle=%0d actual=hung expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end
endmodule